// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single capture/compare channel that sits beside the 16-bit counter of a general-purpose timer. It works in one of two modes, picked by a mode input. In compare mode, software writes a compare value through a small register port. The value reaches an active compare register in one of two ways. Without buffering, it goes there directly. With buffering, it waits in a shadow register until the timer signals an update event. The channel compares the active value with the running counter and drives a compare output. That output is high while the counter is below the active value, which gives a PWM-like waveform.

In capture mode, the same shadow register becomes a holding register. A capture strobe copies the present counter value into it, and software reads the value back. A three-state flag machine tracks whether the held value is unread and whether a capture was overwritten before it was read. The states are `FL_EMPTY`, `FL_HELD` and `FL_OVERRUN`, with these transitions:
- A capture moves the machine from EMPTY to HELD.
- A capture moves it from HELD to OVERRUN, and OVERRUN stays where it is on a further capture.
- A read without a capture returns the machine to EMPTY from any state.
- A read in the same cycle as a capture leaves it in HELD.

Top module: `cc_channel`

## Requirements
- R1: After reset, the read value is 0x0000, both flags are low and the compare output is low.
- R2: In compare mode (`mode_i`=0) with `preload_en_i`=0, a write takes effect in the active compare value from the next cycle. The read value equals the written data.
- R3: In compare mode with `preload_en_i`=1, a write changes the read value but leaves the active compare value unchanged when no update event arrives.
- R4: In compare mode with `preload_en_i`=1, an update event copies the shadow value into the active value. If a write arrives in the same cycle, the active value takes the old shadow contents and the shadow takes the new data.
- R5: `cmp_o` is high exactly when `mode_i`=0 and the counter is below the active value. It is a combinational function of the present counter. In capture mode `cmp_o` is low.
- R6: In capture mode (`mode_i`=1), a capture strobe stores the counter value, and the read port returns it from the next cycle.
- R7: In capture mode, when a capture strobe and a write fall in the same cycle, the captured counter value is stored and the write is dropped.
- R8: A capture sets `cap_flag_o`, and a read without a capture clears it. A read together with a capture leaves `cap_flag_o` set and `ovr_flag_o` clear.
- R9: A second capture before a read sets `ovr_flag_o`, and a read then clears both flags.
- R10: A capture strobe in compare mode changes neither the stored value nor the flags. An update event in capture mode leaves the active compare value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 16 | Running timer counter value |
| mode_i | input | 1 | 0 = compare mode, 1 = capture mode |
| preload_en_i | input | 1 | 1 = buffered compare value, moved on update |
| update_i | input | 1 | Update event strobe |
| capture_i | input | 1 | Capture event strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_en_i | input | 1 | Register read strobe (clears flags) |
| rd_data_o | output | 16 | Register read value (shadow / captured value) |
| cmp_o | output | 1 | Compare output |
| cap_flag_o | output | 1 | Unread capture present |
| ovr_flag_o | output | 1 | Capture overwritten before read |

## Verification
A wrong active compare value never shows at the read port. It shows only on `cmp_o`, and only when the counter sits between the right and the wrong value. For that reason the bench sweeps the counter across each programmed threshold, including the values just below, at and just above it. A wrong shadow or holding value shows on `rd_data_o` one cycle after the faulty write or capture. A wrong flag state shows on the flag outputs in the cycle after the event that caused it. The bench's reference model is compared on every clock, so every divergence is reported within one cycle.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [1:0] {
        FL_EMPTY   = 2'd0,
        FL_HELD    = 2'd1,
        FL_OVERRUN = 2'd2
    } flag_state_t;
endpackage

// File: rtl/cc_store.sv
module cc_store #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_mode,
    input  logic          pre_en,
    input  logic          upd,
    input  logic          cap,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] cnt,
    output logic [DW-1:0] shadow_q,
    output logic [DW-1:0] active_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else if (!cap_mode) begin
            if (wr_en) shadow_q <= wr_data;
            if (wr_en && !pre_en) active_q <= wr_data;
            else if (pre_en && upd) active_q <= shadow_q;
        end else begin
            if (cap) shadow_q <= cnt;
            else if (wr_en) shadow_q <= wr_data;
        end
    end

    // R2
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode && wr_en && !pre_en) |=> (active_q == $past(wr_data)));
    // R3
    preload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode && pre_en && !upd) |=> $stable(active_q));
    // R4
    update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode && pre_en && upd) |=> (active_q == $past(shadow_q)));
    // R6
    capture_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && cap) |=> (shadow_q == $past(cnt)));
    // R10
    cap_mode_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_mode |=> $stable(active_q));
endmodule

// File: rtl/cc_flags.sv
module cc_flags
    import cc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_ev,
    input  logic rd_ev,
    output logic cap_flag,
    output logic ovr_flag
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_EMPTY: begin
                if (cap_ev) state_d = FL_HELD;
            end
            FL_HELD: begin
                if (cap_ev && rd_ev) state_d = FL_HELD;
                else if (cap_ev)     state_d = FL_OVERRUN;
                else if (rd_ev)      state_d = FL_EMPTY;
            end
            FL_OVERRUN: begin
                if (cap_ev && rd_ev) state_d = FL_HELD;
                else if (rd_ev)      state_d = FL_EMPTY;
            end
            default: state_d = FL_EMPTY;
        endcase
    end

    always_comb begin
        cap_flag = 1'b0;
        ovr_flag = 1'b0;
        unique case (state_q)
            FL_EMPTY:   ;
            FL_HELD:    cap_flag = 1'b1;
            FL_OVERRUN: begin
                cap_flag = 1'b1;
                ovr_flag = 1'b1;
            end
            default: ;
        endcase
    end

    // R8
    cap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> cap_flag);
    // R9
    second_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && cap_ev && !rd_ev) |=> ovr_flag);
    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ev && !cap_ev) |=> (!cap_flag && !ovr_flag));
endmodule

// File: rtl/cc_compare.sv
module cc_compare #(
    parameter int DW = 16
) (
    input  logic          cap_mode,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] active,
    output logic          cmp_out
);
    always_comb begin
        cmp_out = !cap_mode && (cnt < active);
    end
endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cnt_i,
    input  logic          mode_i,
    input  logic          preload_en_i,
    input  logic          update_i,
    input  logic          capture_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_en_i,
    output logic [DW-1:0] rd_data_o,
    output logic          cmp_o,
    output logic          cap_flag_o,
    output logic          ovr_flag_o
);
    logic [DW-1:0] shadow_w;
    logic [DW-1:0] active_w;
    logic          cap_ev_w;

    assign cap_ev_w  = mode_i && capture_i;
    assign rd_data_o = shadow_w;

    cc_store #(.DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_mode (mode_i),
        .pre_en   (preload_en_i),
        .upd      (update_i),
        .cap      (capture_i),
        .wr_en    (wr_en_i),
        .wr_data  (wr_data_i),
        .cnt      (cnt_i),
        .shadow_q (shadow_w),
        .active_q (active_w)
    );

    cc_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_ev   (cap_ev_w),
        .rd_ev    (rd_en_i),
        .cap_flag (cap_flag_o),
        .ovr_flag (ovr_flag_o)
    );

    cc_compare #(.DW(DW)) u_cmp (
        .cap_mode (mode_i),
        .cnt      (cnt_i),
        .active   (active_w),
        .cmp_out  (cmp_o)
    );

    // R10
    cmp_mode_ignores_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !wr_en_i) |=> $stable(rd_data_o));
    // R7
    cap_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && capture_i && wr_en_i) |=> (rd_data_o == $past(cnt_i)));
    // R5
    cmp_low_in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |-> !cmp_o);
endmodule

// File: tb/sim_cc_channel.sv
module sim_cc_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i = '0;
    logic        mode_i = 1'b0;
    logic        preload_en_i = 1'b0;
    logic        update_i = 1'b0;
    logic        capture_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        rd_en_i = 1'b0;
    logic [15:0] rd_data_o;
    logic        cmp_o, cap_flag_o, ovr_flag_o;

    int total = 0;
    int bad = 0;
    int m_sh = 0;
    int m_act = 0;
    int m_st = 0;

    always #4 clk = ~clk;

    cc_channel u0 (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .mode_i(mode_i),
        .preload_en_i(preload_en_i), .update_i(update_i), .capture_i(capture_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
        .rd_data_o(rd_data_o), .cmp_o(cmp_o), .cap_flag_o(cap_flag_o),
        .ovr_flag_o(ovr_flag_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        int exp_cmp;
        exp_cmp = (!mode_i && (int'(cnt_i) < m_act)) ? 1 : 0;
        chk(tag, "rd_data", int'(rd_data_o), m_sh);
        chk(tag, "cmp", int'(cmp_o), exp_cmp);
        chk(tag, "cap_flag", int'(cap_flag_o), (m_st != 0) ? 1 : 0);
        chk(tag, "ovr_flag", int'(ovr_flag_o), (m_st == 2) ? 1 : 0);
    endtask

    // one clock: drive at negedge, model updates at posedge, compare after edge
    task automatic cyc(input string tag, input bit md, input bit pe, input bit up,
                       input bit cp, input bit wr, input int wd, input bit rd, input int cn);
        bit capev;
        @(negedge clk);
        mode_i = md; preload_en_i = pe; update_i = up; capture_i = cp;
        wr_en_i = wr; wr_data_i = 16'(wd); rd_en_i = rd; cnt_i = 16'(cn);
        @(posedge clk);
        if (!md) begin
            if (wr && !pe) m_act = wd;
            else if (pe && up) m_act = m_sh;
            if (wr) m_sh = wd;
        end else begin
            if (cp) m_sh = cn;
            else if (wr) m_sh = wd;
        end
        capev = md && cp;
        if (capev && rd) m_st = 1;
        else if (capev) m_st = (m_st == 0) ? 1 : 2;
        else if (rd) m_st = 0;
        #1;
        compare_all(tag);
    endtask

    initial begin
        #(8 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare_all("R1");

        // R2 write-through
        cyc("R2", 0, 0, 0, 0, 1, 'h1234, 0, 'h1000);
        cyc("R5", 0, 0, 0, 0, 0, 0, 0, 'h1233);
        cyc("R5", 0, 0, 0, 0, 0, 0, 0, 'h1234);
        cyc("R5", 0, 0, 0, 0, 0, 0, 0, 'h1235);
        // R3 preload holds
        cyc("R3", 0, 1, 0, 0, 1, 'h0100, 0, 'h0200);
        cyc("R3", 0, 1, 0, 0, 0, 0, 0, 'h1000);
        // R4 update transfer
        cyc("R4", 0, 1, 1, 0, 0, 0, 0, 'h0200);
        cyc("R4", 0, 1, 0, 0, 0, 0, 0, 'h00FF);
        cyc("R4", 0, 1, 1, 0, 1, 'h3000, 0, 'h00FF);
        cyc("R4", 0, 1, 0, 0, 0, 0, 0, 'h0100);
        cyc("R4", 0, 1, 1, 0, 0, 0, 0, 'h2FFF);
        cyc("R4", 0, 1, 0, 0, 0, 0, 0, 'h3000);
        // R5 sweep and edges
        for (int i = 0; i < 40; i++) begin
            cyc("R5", 0, 1, 0, 0, 0, 0, 0, 'h2FEC + i);
        end
        cyc("R5", 0, 1, 0, 0, 0, 0, 0, 'hFFFF);
        cyc("R5", 0, 0, 0, 0, 1, 'h0000, 0, 'h0000);
        cyc("R5", 0, 0, 0, 0, 0, 0, 0, 'h0000);
        cyc("R2", 0, 0, 0, 0, 1, 'hFFFF, 0, 'hFFFE);
        cyc("R5", 0, 0, 0, 0, 0, 0, 0, 'hFFFF);
        // R10 capture ignored in compare mode
        cyc("R10", 0, 0, 0, 1, 0, 0, 0, 'h0007);
        cyc("R10", 0, 0, 0, 0, 0, 0, 0, 'h0007);
        // R6 capture
        cyc("R6", 1, 0, 0, 1, 0, 0, 0, 'hABCD);
        cyc("R6", 1, 0, 0, 0, 0, 0, 0, 'h0001);
        // R9 overcapture
        cyc("R9", 1, 0, 0, 1, 0, 0, 0, 'h0042);
        cyc("R9", 1, 0, 0, 1, 0, 0, 0, 'h0043);
        cyc("R9", 1, 0, 0, 0, 0, 0, 1, 'h0044);
        // R8 flag set / clear and read+capture
        cyc("R8", 1, 0, 0, 1, 0, 0, 0, 'h0500);
        cyc("R8", 1, 0, 0, 0, 0, 0, 1, 'h0501);
        cyc("R8", 1, 0, 0, 1, 0, 0, 0, 'h0600);
        cyc("R8", 1, 0, 0, 1, 0, 0, 1, 'h0601);
        cyc("R8", 1, 0, 0, 1, 0, 0, 0, 'h0602);
        cyc("R8", 1, 0, 0, 1, 0, 0, 1, 'h0603);
        cyc("R8", 1, 0, 0, 0, 0, 0, 1, 'h0604);
        // R7 capture beats write
        cyc("R7", 1, 0, 0, 1, 1, 'h7777, 0, 'h0ABC);
        cyc("R7", 1, 0, 0, 0, 1, 'h7777, 1, 'h0ABD);
        // R10 update ignored in capture mode; active value still 0xFFFF
        cyc("R10", 1, 1, 1, 0, 0, 0, 0, 'h0010);
        cyc("R10", 0, 1, 0, 0, 0, 0, 0, 'hFFFE);
        cyc("R10", 0, 1, 0, 0, 0, 0, 0, 'hFFFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule